// File: doc/BRIEF.md
# Test-Overridable Bypass Clock Divider

This block produces a clock from a free-running input clock. The output is either the input clock itself (bypass) or the input clock divided by four. In normal operation, a select input driven by external control logic picks the ratio. The divided clock has a 50% duty cycle. It comes from the most significant bit of a small counter that the active-low reset clears.

For at-speed scan testing, the fastest clock must reach the downstream logic without interruption. When the test-mode input is high, the functional select and the functional reset are both ignored, and the output is forced onto the undivided path. In that state the counter flops can sit on scan chains and toggle freely, and the output clock is not disturbed. The input clock must be free-running and must not come from a gated, controller-driven source.

Top module: `clkdiv_bypass_top`

## Requirements
- R1: With `test_mode` = 0, reset released and `div_sel` = 0 (bypass encoding), `clk_out` equals `clk_in` at every instant.
- R2: With `test_mode` = 0, reset released and `div_sel` = 1 (divide encoding), `clk_out` has a period of four `clk_in` periods. It is high for two input periods and low for two, and it changes only just after rising edges of `clk_in`.
- R3: With `test_mode` = 1, `clk_out` equals `clk_in` whatever the value of `div_sel`.
- R4: With `test_mode` = 1, a low `rst_n` has no effect. The counter keeps advancing on every rising input edge, and `clk_out` keeps following `clk_in`.
- R5: With `test_mode` = 0 and `rst_n` = 0, the counter is held at zero, so the divided output is low and `clk_out` stays low while divide is selected.
- R6: After `rst_n` rises with divide selected and `test_mode` = 0, `clk_out` is low after the first rising `clk_in` edge and high after the second and third. It is low again after the fourth, and the pattern repeats every four edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Free-running source clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous; masked in test mode |
| div_sel | input | 1 | Functional ratio choice: 0 = pass through, 1 = divide by four |
| test_mode | input | 1 | Scan test enable; forces the undivided path and masks the reset |
| clk_out | output | 1 | Selected output clock |

## Verification
The hardest case to reach from the ports is proving that the reset is really masked in test mode. While test mode is high, the output follows the input no matter what the counter does, so the counter state is hidden. The stimulus first clears the counter with a functional reset. It then raises test mode while keeping the reset low, lets one rising edge pass, and finally releases the reset and drops test mode together between edges. The divided output then rises after the very next edge only if the counter advanced during the masked reset. A counter that had obeyed the reset would need two edges.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Output path selection for the clock multiplexer.
    typedef enum logic {
        PATH_DIV = 1'b0,
        PATH_BYP = 1'b1
    } path_e;

    // log2 of the division ratio used by default (ratio 4).
    localparam int unsigned DIV_LOG2_DEF = 2;

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
    import clkdiv_pkg::*;
(
    input  logic  test_mode_i,
    input  logic  rst_n_i,
    input  logic  div_sel_i,
    output path_e path_o,
    output logic  rst_eff_n_o
);

    typedef struct packed {
        path_e path;
        logic  rst_n;
    } ctrl_t;

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = '{path: PATH_DIV, rst_n: 1'b0};
        // Test mode overrides the functional ratio choice.
        if (test_mode_i || !div_sel_i) begin
            ctrl_d.path = PATH_BYP;
        end
        // Test mode masks the functional reset so scan shifting is unaffected.
        ctrl_d.rst_n = rst_n_i | test_mode_i;
    end

    assign path_o      = ctrl_d.path;
    assign rst_eff_n_o = ctrl_d.rst_n;

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int unsigned DIV_LOG2 = clkdiv_pkg::DIV_LOG2_DEF
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic div_o
);

    localparam int unsigned CNT_W = (DIV_LOG2 < 2) ? 2 : DIV_LOG2;
    localparam int unsigned LO_W  = CNT_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       lo_full;

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + CNT_W'(1);
        st_d.seen = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_full = &st_q.cnt[LO_W-1:0];
    assign div_o   = st_q.cnt[CNT_W-1];

    // MSB flips exactly when the lower bits wrap.
    AST_DIV_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q.seen && $past(lo_full)) |-> (div_o != $past(div_o))); // R2

    // MSB holds on every other edge.
    AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q.seen && !$past(lo_full)) |-> $stable(div_o)); // R2

endmodule

// File: rtl/clkdiv_mux.sv
module clkdiv_mux
    import clkdiv_pkg::*;
(
    input  logic  clk_i,
    input  logic  div_i,
    input  path_e path_i,
    input  logic  test_mode_i,
    input  logic  div_sel_i,
    input  logic  rst_n_i,
    output logic  clk_o
);

    always_comb begin
        clk_o = (path_i == PATH_BYP) ? clk_i : div_i;
    end

    // Test mode must always land on the undivided path.
    AST_BYPASS_FORCED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        test_mode_i |-> (path_i == PATH_BYP)); // R3

    // Outside test mode the functional select decides the path.
    AST_FUNC_SELECT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !test_mode_i |-> ((path_i == PATH_BYP) == !div_sel_i)); // R1

endmodule

// File: rtl/clkdiv_bypass_top.sv
module clkdiv_bypass_top
    import clkdiv_pkg::*;
#(
    parameter int unsigned DIV_LOG2 = DIV_LOG2_DEF
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic div_sel,
    input  logic test_mode,
    output logic clk_out
);

    path_e path_w;
    logic  rst_eff_n_w;
    logic  div_w;

    clkdiv_ctrl i_ctrl (
        .test_mode_i (test_mode),
        .rst_n_i     (rst_n),
        .div_sel_i   (div_sel),
        .path_o      (path_w),
        .rst_eff_n_o (rst_eff_n_w)
    );

    clkdiv_counter #(
        .DIV_LOG2 (DIV_LOG2)
    ) i_counter (
        .clk_i   (clk_in),
        .rst_n_i (rst_eff_n_w),
        .div_o   (div_w)
    );

    clkdiv_mux i_mux (
        .clk_i       (clk_in),
        .div_i       (div_w),
        .path_i      (path_w),
        .test_mode_i (test_mode),
        .div_sel_i   (div_sel),
        .rst_n_i     (rst_eff_n_w),
        .clk_o       (clk_out)
    );

endmodule

// File: tb/test_clkdiv_bypass_top.sv
`timescale 1ns/1ps
module test_clkdiv_bypass_top;

    logic clk_in = 1'b0;
    logic rst_n;
    logic div_sel;
    logic test_mode;
    logic clk_out;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk_in = ~clk_in;

    clkdiv_bypass_top i_clkdiv_bypass_top (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .div_sel   (div_sel),
        .test_mode (test_mode),
        .clk_out   (clk_out)
    );

    // {test_mode, div_sel}
    localparam logic [1:0] VEC [6] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00};

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic hi [8];
        logic lo [8];
        rst_n = 1'b0; div_sel = 1'b1; test_mode = 1'b0;

        // R5: reset holds output low with divide selected
        repeat (3) @(posedge clk_in);
        #2.5 chk("R5", clk_out, 1'b0);
        #5   chk("R5", clk_out, 1'b0);

        // R6: first divided rising edge after second input edge
        @(negedge clk_in); rst_n = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk_in);
            #2.5 chk("R6", clk_out, ((k % 4) == 2) || ((k % 4) == 3));
        end

        // Table walk: R1, R2, R3
        foreach (VEC[v]) begin
            @(negedge clk_in);
            test_mode = VEC[v][1];
            div_sel   = VEC[v][0];
            repeat (2) @(posedge clk_in);
            for (int i = 0; i < 8; i++) begin
                @(posedge clk_in);
                #2.5 hi[i] = clk_out;
                #5   lo[i] = clk_out;
            end
            if (VEC[v][1] || !VEC[v][0]) begin
                for (int i = 0; i < 8; i++) begin
                    chk(VEC[v][1] ? "R3" : "R1", hi[i], 1'b1);
                    chk(VEC[v][1] ? "R3" : "R1", lo[i], 1'b0);
                end
            end else begin
                for (int i = 0; i < 4; i++) begin
                    chk("R2", hi[i + 4], hi[i]);
                    chk("R2", lo[i], hi[i]);
                end
                chk("R2", hi[2], !hi[0]);
                chk("R2", hi[3], !hi[1]);
                chk("R2", 1'(({31'b0, hi[0]} + hi[1] + hi[2] + hi[3]) == 2), 1'b1);
            end
        end

        // R4: reset masked in test mode, counter keeps running
        @(negedge clk_in);
        rst_n = 1'b0; test_mode = 1'b0; div_sel = 1'b1;
        repeat (2) @(posedge clk_in);
        #2.5 chk("R5", clk_out, 1'b0);
        @(negedge clk_in); test_mode = 1'b1;
        @(posedge clk_in);
        #2.5 chk("R4", clk_out, 1'b1);
        #5   chk("R4", clk_out, 1'b0);
        rst_n = 1'b1;
        test_mode = 1'b0;
        #1   chk("R4", clk_out, 1'b0);
        @(posedge clk_in);
        #2.5 chk("R4", clk_out, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule